// File: doc/BRIEF.md
# RAM-Backed Fibonacci Table Builder

This block fills an internal single-clock simple dual-port RAM with consecutive Fibonacci terms, one term per address, starting at address 0. After a start pulse, a small state machine stores the two seed terms. It then repeats a four-state step. Each step reads the two preceding terms back out of the RAM, adds them, and writes the sum to the next address. No working copies of the terms are kept between steps. The RAM output is registered, so every read is spread over separate address and capture states.

Building stops when the last RAM address has been written, or when the next sum no longer fits the data width. A sum that does not fit is discarded and never written. Once the table is complete, `done` stays high until reset. While the controller is idle or finished, an external read address drives the RAM read port, so the table can be dumped one word per clock.

Top module: `fib_ram_builder`

## Requirements
- R1: After a synchronous reset, `done` is low and no RAM location changes until `start` is seen high at a clock edge.
- R2: The build writes value 0 at address 0 and value 1 at address 1.
- R3: Every address n from 2 up to the last written address holds the sum of the contents of addresses n-2 and n-1.
- R4: The edge that samples `start` counts as edge 0. `done` first reads high after edge 2+4*(L-1), where L is the address at which the loop ends: the last address on a full stop, or the rejected address on an overflow stop.
- R5: When no overflow occurs, the last address written is 2**ADDR_WIDTH-1, and the block then raises `done` and writes nothing more.
- R6: A sum that exceeds DATA_WIDTH bits is not written, and `done` is raised. That location keeps its power-up value of zero (the RAM starts all zeros). If the overflow falls on the last address, the overflow still wins and that address stays zero.
- R7: `start` has no effect outside the idle state. A pulse during a build does not change the result or the `done` timing, and a pulse while `done` is high leaves `done` high and the table unchanged.
- R8: In the idle and done states, `rd_data` shows the contents of the location given by `rd_addr` one clock edge after that address is applied.
- R9: Reset returns the block to idle with `done` low but keeps the RAM contents. A later start rebuilds an identical table with the same timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for the controller and the RAM |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a build when the block is idle |
| rd_addr | input | ADDR_WIDTH | External read address, used in the idle and done states |
| rd_data | output | DATA_WIDTH | Registered RAM read data |
| done | output | 1 | High once the table is complete, until reset |

## Verification
Two different stop conditions can fall in the same write state: the overflow of the sum and the arrival at the last address. The bench runs an instance with 9-bit data and 4-bit addresses. In that instance term 15 (610) is both the first term that does not fit and the term aimed at the last address. The bench checks that address 15 still reads zero, that address 14 holds 377, and that `done` rises after edge 58. A second overlap is a `start` pulse arriving in the middle of a build. The bench checks for it through unchanged `done` timing and contents in all three instances.

// File: rtl/fib_pkg.sv
package fib_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEED0,
    ST_SEED1,
    ST_RD_A,
    ST_RD_B,
    ST_CAPTURE,
    ST_WRITE,
    ST_DONE
  } fib_state_t;

endpackage

// File: rtl/fib_sdp_ram.sv
// Simple dual-port RAM, one clock, registered read port.
// A read and a write to the same address in one cycle returns the old word.
module fib_sdp_ram #(
  parameter int DATA_WIDTH = 64,
  parameter int ADDR_WIDTH = 6
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [ADDR_WIDTH-1:0] waddr,
  input  logic [DATA_WIDTH-1:0] wdata,
  input  logic [ADDR_WIDTH-1:0] raddr,
  output logic [DATA_WIDTH-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_WIDTH;

  logic [DATA_WIDTH-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/fib_add_carry.sv
// Unsigned adder that also reports the carry out of DATA_WIDTH bits.
module fib_add_carry #(
  parameter int DATA_WIDTH = 64
) (
  input  logic [DATA_WIDTH-1:0] a,
  input  logic [DATA_WIDTH-1:0] b,
  output logic [DATA_WIDTH-1:0] sum,
  output logic                  carry
);

  always_comb begin
    {carry, sum} = {1'b0, a} + {1'b0, b};
  end

endmodule

// File: rtl/fib_seq_ctrl.sv
// Sequencer: seeds, then read n-2, read n-1, capture, write n.
module fib_seq_ctrl
  import fib_pkg::*;
#(
  parameter int DATA_WIDTH = 64,
  parameter int ADDR_WIDTH = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [DATA_WIDTH-1:0] ram_rdata,
  output logic                  ram_we,
  output logic [ADDR_WIDTH-1:0] ram_waddr,
  output logic [DATA_WIDTH-1:0] ram_wdata,
  output logic [ADDR_WIDTH-1:0] seq_raddr,
  output logic                  host_port,
  output logic                  done
);

  localparam logic [ADDR_WIDTH-1:0] LAST_ADDR = {ADDR_WIDTH{1'b1}};
  localparam logic [ADDR_WIDTH-1:0] ONE_A     = ADDR_WIDTH'(1);
  localparam logic [ADDR_WIDTH-1:0] TWO_A     = ADDR_WIDTH'(2);
  localparam logic [DATA_WIDTH-1:0] ONE_D     = DATA_WIDTH'(1);

  fib_state_t            state_q, state_d;
  logic [ADDR_WIDTH-1:0] idx_q;
  logic [DATA_WIDTH-1:0] op_a_q, op_b_q;
  logic [DATA_WIDTH-1:0] sum;
  logic                  carry;
  logic                  at_last;

  fib_add_carry #(.DATA_WIDTH(DATA_WIDTH)) u_add (
    .a    (op_a_q),
    .b    (op_b_q),
    .sum  (sum),
    .carry(carry)
  );

  assign at_last = (idx_q == LAST_ADDR);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start) state_d = ST_SEED0;
      ST_SEED0:   state_d = ST_SEED1;
      ST_SEED1:   state_d = ST_RD_A;
      ST_RD_A:    state_d = ST_RD_B;
      ST_RD_B:    state_d = ST_CAPTURE;
      ST_CAPTURE: state_d = ST_WRITE;
      ST_WRITE:   state_d = (carry || at_last) ? ST_DONE : ST_RD_A;
      ST_DONE:    state_d = ST_DONE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      op_a_q  <= '0;
      op_b_q  <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= (state_d == ST_DONE);
      unique case (state_q)
        ST_IDLE:            idx_q  <= '0;
        ST_SEED0, ST_SEED1: idx_q  <= idx_q + ONE_A;
        ST_RD_B:            op_a_q <= ram_rdata;
        ST_CAPTURE:         op_b_q <= ram_rdata;
        ST_WRITE:           if (!carry && !at_last) idx_q <= idx_q + ONE_A;
        default: ;
      endcase
    end
  end

  always_comb begin
    ram_waddr = idx_q;
    ram_we    = (state_q == ST_SEED0) || (state_q == ST_SEED1) ||
                ((state_q == ST_WRITE) && !carry);
    unique case (state_q)
      ST_SEED0: ram_wdata = '0;
      ST_SEED1: ram_wdata = ONE_D;
      default:  ram_wdata = sum;
    endcase
  end

  assign seq_raddr = (state_q == ST_RD_A) ? (idx_q - TWO_A) : (idx_q - ONE_A);
  assign host_port = (state_q == ST_IDLE) || (state_q == ST_DONE);

endmodule

// File: rtl/fib_ram_builder.sv
module fib_ram_builder #(
  parameter int DATA_WIDTH = 64,
  parameter int ADDR_WIDTH = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [ADDR_WIDTH-1:0] rd_addr,
  output logic [DATA_WIDTH-1:0] rd_data,
  output logic                  done
);

  logic                  ram_we;
  logic [ADDR_WIDTH-1:0] ram_waddr;
  logic [DATA_WIDTH-1:0] ram_wdata;
  logic [ADDR_WIDTH-1:0] seq_raddr;
  logic [ADDR_WIDTH-1:0] ram_raddr;
  logic                  host_port;

  fib_seq_ctrl #(
    .DATA_WIDTH(DATA_WIDTH),
    .ADDR_WIDTH(ADDR_WIDTH)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .ram_rdata(rd_data),
    .ram_we   (ram_we),
    .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata),
    .seq_raddr(seq_raddr),
    .host_port(host_port),
    .done     (done)
  );

  assign ram_raddr = host_port ? rd_addr : seq_raddr;

  fib_sdp_ram #(
    .DATA_WIDTH(DATA_WIDTH),
    .ADDR_WIDTH(ADDR_WIDTH)
  ) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .raddr(ram_raddr),
    .rdata(rd_data)
  );

endmodule

// File: rtl/fib_builder_chk.sv
module fib_builder_chk #(
  parameter int DW = 64,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          done,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data
);

  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_data;
  logic          have_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_addr <= '0;
      prev_data <= '0;
      have_prev <= 1'b0;
    end else if (wr_en) begin
      prev_addr <= wr_addr;
      prev_data <= wr_data;
      have_prev <= 1'b1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !done); // R1
  AST_SEED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == '0) |-> wr_data == '0); // R2
  AST_SEED_ONE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(1)) |-> wr_data == DW'(1)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && have_prev && wr_addr != '0) |-> wr_addr == AW'(prev_addr + AW'(1))); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wr_en && have_prev && wr_addr > AW'(1)) |-> wr_data >= prev_data); // R6
  AST_QUIET_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_en); // R5
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> done); // R7

endmodule

bind fib_ram_builder fib_builder_chk #(
  .DW(DATA_WIDTH),
  .AW(ADDR_WIDTH)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .done   (done),
  .wr_en  (ram_we),
  .wr_addr(ram_waddr),
  .wr_data(ram_wdata)
);

// File: tb/tb_fib_ram_builder.sv
module tb_fib_ram_builder;

  localparam int AW_A = 6;
  localparam int DW_A = 64;
  localparam int DW_B = 16;
  localparam int AW_C = 4;
  localparam int DW_C = 9;

  // probe table: {address, expected term} for the 64-bit instance
  localparam logic [69:0] PROBE [8] = '{
    {6'd0,  64'd0},
    {6'd1,  64'd1},
    {6'd2,  64'd1},
    {6'd10, 64'd55},
    {6'd20, 64'd6765},
    {6'd47, 64'd2971215073},
    {6'd48, 64'd4807526976},
    {6'd63, 64'd6557470319842}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW_A-1:0] ra_a = '0, ra_b = '0;
  logic [AW_C-1:0] ra_c = '0;
  logic [DW_A-1:0] rd_a;
  logic [DW_B-1:0] rd_b;
  logic [DW_C-1:0] rd_c;
  logic done_a, done_b, done_c;

  fib_ram_builder #(.DATA_WIDTH(DW_A), .ADDR_WIDTH(AW_A)) dut (
    .clk(clk), .rst(rst), .start(start), .rd_addr(ra_a), .rd_data(rd_a), .done(done_a));
  fib_ram_builder #(.DATA_WIDTH(DW_B), .ADDR_WIDTH(AW_A)) dut_ovf (
    .clk(clk), .rst(rst), .start(start), .rd_addr(ra_b), .rd_data(rd_b), .done(done_b));
  fib_ram_builder #(.DATA_WIDTH(DW_C), .ADDR_WIDTH(AW_C)) dut_both (
    .clk(clk), .rst(rst), .start(start), .rd_addr(ra_c), .rd_data(rd_c), .done(done_c));

  int checks = 0;
  int fails = 0;
  int edge_cnt = 0;
  int base = 0;
  int t_a, t_b, t_c;
  longint unsigned ref_fib [64];
  logic [63:0] va, vb, vc;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd3(input int a, output logic [63:0] da, output logic [63:0] db,
                     output logic [63:0] dc);
    @(negedge clk);
    ra_a = AW_A'(a);
    ra_b = AW_A'(a);
    ra_c = AW_C'(a);
    @(negedge clk);
    da = 64'(rd_a);
    db = 64'(rd_b);
    dc = 64'(rd_c);
  endtask

  task automatic run_build(input bit poke);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    base = edge_cnt;
    t_a = -1; t_b = -1; t_c = -1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (done_a && t_a < 0) t_a = edge_cnt - base;
      if (done_b && t_b < 0) t_b = edge_cnt - base;
      if (done_c && t_c < 0) t_c = edge_cnt - base;
      start = poke && (edge_cnt - base == 20);
      if (t_a >= 0 && t_b >= 0 && t_c >= 0) break;
    end
    start = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    ref_fib[0] = 0;
    ref_fib[1] = 1;
    for (int i = 2; i < 64; i++) ref_fib[i] = ref_fib[i-2] + ref_fib[i-1];

    // R1: reset state, no start
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk("R1 done_a idle", 64'(done_a), 0);
    chk("R1 done_b idle", 64'(done_b), 0);
    chk("R1 done_c idle", 64'(done_c), 0);
    rd3(5, va, vb, vc);
    chk("R1 no write before start", va, 0);

    // build with a start pulse in the middle (R7)
    run_build(1'b1);
    chk("R4 R5 R7 full-stop timing", 64'(t_a), 250);
    chk("R4 R6 overflow-stop timing", 64'(t_b), 98);
    chk("R4 R6 joint-stop timing", 64'(t_c), 58);

    // table walk: vectors
    foreach (PROBE[i]) begin
      rd3(int'(PROBE[i][69:64]), va, vb, vc);
      chk($sformatf("R3 R8 probe addr %0d", PROBE[i][69:64]), va, PROBE[i][63:0]);
    end

    // full dump against reference
    for (int a = 0; a < 64; a++) begin
      rd3(a, va, vb, vc);
      chk($sformatf("%s dut addr %0d", (a < 2) ? "R2" : "R3", a), va, ref_fib[a]);
      if (a <= 24)
        chk($sformatf("R3 dut_ovf addr %0d", a), vb, ref_fib[a]);
      else if (a == 25)
        chk("R6 dut_ovf rejected term left zero", vb, 0);
    end

    // joint stop: overflow on the last address
    rd3(14, va, vb, vc);
    chk("R6 dut_both addr 14", vc, 377);
    rd3(15, va, vb, vc);
    chk("R6 dut_both last address not written", vc, 0);

    // R7: start while done
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk("R7 done_a held", 64'(done_a), 1);
    chk("R7 done_c held", 64'(done_c), 1);
    rd3(63, va, vb, vc);
    chk("R7 dut table unchanged", va, ref_fib[63]);
    rd3(15, va, vb, vc);
    chk("R7 dut_both table unchanged", vc, 0);

    // R9: reset keeps contents
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R9 done_a cleared", 64'(done_a), 0);
    chk("R9 done_b cleared", 64'(done_b), 0);
    rd3(40, va, vb, vc);
    chk("R9 R8 contents kept addr 40", va, ref_fib[40]);
    rd3(24, va, vb, vc);
    chk("R9 R8 dut_ovf kept addr 24", vb, ref_fib[24]);

    // R9: rebuild, same timing and table
    run_build(1'b0);
    chk("R9 R4 rebuild timing", 64'(t_a), 250);
    chk("R9 R4 rebuild overflow timing", 64'(t_b), 98);
    rd3(63, va, vb, vc);
    chk("R9 rebuild addr 63", va, ref_fib[63]);
    rd3(1, va, vb, vc);
    chk("R9 R2 rebuild addr 1", va, 1);

    summary();
  end

endmodule